// File: doc/BRIEF.md
# Prioritized Line Interrupt Scanner

This block sits between the per-line character logic of a multi-line serial interface and the host. It keeps, for each of 16 user lines and 5 diagnostic receive channels, a receive-pending flag, the last received character and two status bits (break, lost), and for each user line a transmit-done flag. Character arrivals and transmit completions are reported to it through two strobed event inputs. Whenever its interrupt flag is clear it picks one qualifying event in a fixed priority order, formats it into a 16-bit data word and a 16-bit status word, clears the serviced line's flag and status bits, and raises the interrupt flag.

The control is a two-state machine. In state SCAN the block searches every cycle; the transition "post" moves it to POSTED in the cycle where a qualifying event exists. In POSTED the words and the flag are held. The transition "acknowledge" returns it to SCAN on the edge where the host pulses `flag_clear`. The next search happens in the following cycle.

Each line's enable bit comes from the host as a plain vector, one bit per receive channel and one per transmit line. An event whose enable bit is low stays stored and is taken once the bit is set.

Top module: `line_irq_scanner`

## Requirements
- R1: After reset the interrupt flag is low, both words are zero, and no pending, done, break or lost state remains on any line.
- R2: Classes are served in this order: receive-pending on user lines 0 to 15, then transmit-done on user lines 0 to 15, then receive-pending on diagnostic channels 16 to 20.
- R3: Within a class the lowest-numbered qualifying line is chosen, and one search takes exactly one event.
- R4: A receive event qualifies only while `rx_enable[ch]` is 1, a transmit event only while `tx_enable[ln]` is 1. A disabled event stays stored and is taken once its enable bit is set.
- R5: Data word layout: bit 15 is 1 when bits 7:0 of the character hold an odd number of ones, bits 14:10 hold the channel number, and bits 9:0 hold the character.
- R6: Status word layout: bits 14:10 hold the channel, bit 3 marks the diagnostic class, bit 2 is break, bit 1 is lost, and bit 0 marks the transmit class. Bits 15 and 9:4 are zero.
- R7: A transmit-done interrupt returns, in the data word, that line's most recently received character with its parity.
- R8: An event strobed in one cycle is captured at the next edge. If the block is in SCAN, the flag rises at the following edge. Serving an event clears that line's pending flag (receive classes) or its done flag (transmit class), and also its break and lost bits.
- R9: A break arrival sets the line's break bit, stores a zero character and marks the line pending.
- R10: A normal arrival on a line whose pending flag is set sets its lost bit and keeps the newer character. An arrival in the same cycle as the line's receive service counts as fresh and does not set lost.
- R11: While the flag is high no search occurs and both words hold. `flag_clear` drops the flag at the next edge, and a search runs in the cycle after that. `flag_clear` has no effect while the flag is low.
- R12: Transmit strobes for channels 16 and above and receive strobes for channels 21 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Receive event strobe |
| rx_chan | input | 5 | Channel of the receive event (0 to 20) |
| rx_char | input | 10 | Received character |
| rx_break | input | 1 | Receive event is a break |
| tx_valid | input | 1 | Transmit-done strobe |
| tx_chan | input | 5 | Line of the transmit-done event (0 to 15) |
| rx_enable | input | 21 | Receive enable per channel |
| tx_enable | input | 16 | Transmit enable per user line |
| flag_clear | input | 1 | Host acknowledge of the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| data_word | output | 16 | Parity, channel and character of the served event |
| status_word | output | 16 | Channel, class markers and status of the served event |

## Verification
The assertions assume that `flag_clear` is a clean synchronous level and that both event strobes carry channel numbers that are sampled only at clock edges. Under those conditions the flag holds until acknowledged, the words stay stable while posted, and the class markers agree with the channel ranges. The stimulus meets this by changing every input just after a rising edge and by keeping each strobe to a single channel per cycle. In random traffic the channel numbers run past the valid ranges on purpose, and a behavioural model tracks the ignored cases.

// File: rtl/lis_pkg.sv
package lis_pkg;
    localparam int USER_LINES = 16;
    localparam int DIAG_LINES = 5;
    localparam int CHAN_W     = 5;
    localparam int CHAR_W     = 10;
    localparam int WORD_W     = 16;

    typedef enum logic [1:0] {
        CLS_RX   = 2'd0,
        CLS_TX   = 2'd1,
        CLS_DIAG = 2'd2
    } evt_class_e;

    typedef enum logic {
        ST_SCAN   = 1'b0,
        ST_POSTED = 1'b1
    } scan_state_e;
endpackage

// File: rtl/lis_first_set.sv
module lis_first_set #(
    parameter int W  = 16,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/lis_line_store.sv
module lis_line_store
    import lis_pkg::*;
#(
    parameter int NUSER = USER_LINES,
    parameter int NDIAG = DIAG_LINES,
    parameter int CW    = CHAN_W,
    parameter int DW    = CHAR_W,
    localparam int NALL = NUSER + NDIAG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [CW-1:0]        rx_chan,
    input  logic [DW-1:0]        rx_char,
    input  logic                 rx_break,
    input  logic                 tx_valid,
    input  logic [CW-1:0]        tx_chan,
    input  logic                 svc_fire,
    input  evt_class_e           svc_cls,
    input  logic [CW-1:0]        svc_chan,
    output logic [NALL-1:0]      pend,
    output logic [NUSER-1:0]     done,
    output logic [DW-1:0]        rd_char,
    output logic                 rd_brk,
    output logic                 rd_lost
);
    logic [NALL-1:0]         pend_q, brk_q, lost_q;
    logic [NALL-1:0][DW-1:0] chr_q;
    logic [NUSER-1:0]        done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            brk_q  <= '0;
            lost_q <= '0;
            chr_q  <= '0;
            done_q <= '0;
        end else begin
            for (int i = 0; i < NALL; i++) begin
                // service first, then any arrival on the same line
                if (svc_fire && svc_chan == CW'(i)) begin
                    brk_q[i]  <= 1'b0;
                    lost_q[i] <= 1'b0;
                    if (svc_cls != CLS_TX) pend_q[i] <= 1'b0;
                end
                if (rx_valid && rx_chan == CW'(i)) begin
                    pend_q[i] <= 1'b1;
                    if (rx_break) begin
                        brk_q[i] <= 1'b1;
                        chr_q[i] <= '0;
                    end else begin
                        chr_q[i] <= rx_char;
                        if (pend_q[i] && !(svc_fire && svc_chan == CW'(i) && svc_cls != CLS_TX))
                            lost_q[i] <= 1'b1;
                    end
                end
            end
            for (int j = 0; j < NUSER; j++) begin
                if (svc_fire && svc_cls == CLS_TX && svc_chan == CW'(j)) done_q[j] <= 1'b0;
                if (tx_valid && tx_chan == CW'(j)) done_q[j] <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_char = '0;
        rd_brk  = 1'b0;
        rd_lost = 1'b0;
        for (int i = 0; i < NALL; i++) begin
            if (svc_chan == CW'(i)) begin
                rd_char = chr_q[i];
                rd_brk  = brk_q[i];
                rd_lost = lost_q[i];
            end
        end
    end

    assign pend = pend_q;
    assign done = done_q;
endmodule

// File: rtl/lis_word_fmt.sv
module lis_word_fmt
    import lis_pkg::*;
(
    input  logic [CHAN_W-1:0] chan,
    input  logic [CHAR_W-1:0] chr,
    input  logic              brk,
    input  logic              lost,
    input  evt_class_e        cls,
    output logic [WORD_W-1:0] data_w,
    output logic [WORD_W-1:0] stat_w
);
    assign data_w = {^chr[7:0], chan, chr};
    assign stat_w = {1'b0, chan, 6'b0, (cls == CLS_DIAG), brk, lost, (cls == CLS_TX)};
endmodule

// File: rtl/line_irq_scanner.sv
module line_irq_scanner
    import lis_pkg::*;
#(
    parameter int USER_N = USER_LINES,
    parameter int DIAG_N = DIAG_LINES,
    localparam int ALL_N = USER_N + DIAG_N,
    localparam int UIW   = $clog2(USER_N),
    localparam int DIW   = $clog2(DIAG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [4:0]        rx_chan,
    input  logic [9:0]        rx_char,
    input  logic              rx_break,
    input  logic              tx_valid,
    input  logic [4:0]        tx_chan,
    input  logic [20:0]       rx_enable,
    input  logic [15:0]       tx_enable,
    input  logic              flag_clear,
    output logic              irq_flag,
    output logic [15:0]       data_word,
    output logic [15:0]       status_word
);
    scan_state_e state_q, state_d;

    logic [ALL_N-1:0]  pend;
    logic [USER_N-1:0] done;
    logic [ALL_N-1:0]  rx_qual;
    logic [USER_N-1:0] tx_qual;

    logic           u_found, t_found, d_found;
    logic [UIW-1:0] u_idx, t_idx;
    logic [DIW-1:0] d_idx;

    logic              sel_found;
    evt_class_e        sel_cls;
    logic [CHAN_W-1:0] sel_chan;
    logic              svc_fire;

    logic [CHAR_W-1:0] rd_char;
    logic              rd_brk, rd_lost;
    logic [WORD_W-1:0] fmt_data, fmt_stat;
    logic [WORD_W-1:0] data_q, stat_q;

    assign rx_qual = pend & rx_enable;
    assign tx_qual = done & tx_enable;

    lis_first_set #(.W(USER_N)) u_pick_rx (
        .req(rx_qual[USER_N-1:0]), .found(u_found), .idx(u_idx));
    lis_first_set #(.W(USER_N)) u_pick_tx (
        .req(tx_qual), .found(t_found), .idx(t_idx));
    lis_first_set #(.W(DIAG_N)) u_pick_dg (
        .req(rx_qual[ALL_N-1:USER_N]), .found(d_found), .idx(d_idx));

    always_comb begin
        sel_found = u_found | t_found | d_found;
        sel_cls   = CLS_RX;
        sel_chan  = '0;
        if (u_found) begin
            sel_cls  = CLS_RX;
            sel_chan = CHAN_W'(u_idx);
        end else if (t_found) begin
            sel_cls  = CLS_TX;
            sel_chan = CHAN_W'(t_idx);
        end else if (d_found) begin
            sel_cls  = CLS_DIAG;
            sel_chan = CHAN_W'(USER_N) + CHAN_W'(d_idx);
        end
    end

    assign svc_fire = (state_q == ST_SCAN) && sel_found;

    lis_line_store #(.NUSER(USER_N), .NDIAG(DIAG_N)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_chan  (rx_chan),
        .rx_char  (rx_char),
        .rx_break (rx_break),
        .tx_valid (tx_valid),
        .tx_chan  (tx_chan),
        .svc_fire (svc_fire),
        .svc_cls  (sel_cls),
        .svc_chan (sel_chan),
        .pend     (pend),
        .done     (done),
        .rd_char  (rd_char),
        .rd_brk   (rd_brk),
        .rd_lost  (rd_lost)
    );

    lis_word_fmt u_fmt (
        .chan   (sel_chan),
        .chr    (rd_char),
        .brk    (rd_brk),
        .lost   (rd_lost),
        .cls    (sel_cls),
        .data_w (fmt_data),
        .stat_w (fmt_stat)
    );

    // next state: post / acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:   if (sel_found)  state_d = ST_POSTED;
            ST_POSTED: if (flag_clear) state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            stat_q <= '0;
        end else if (svc_fire) begin
            data_q <= fmt_data;
            stat_q <= fmt_stat;
        end
    end

    assign irq_flag    = (state_q == ST_POSTED);
    assign data_word   = data_q;
    assign status_word = stat_q;
endmodule

// File: rtl/line_irq_scanner_chk.sv
module line_irq_scanner_chk #(
    parameter int USER_N = 16,
    parameter int DIAG_N = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        flag_clear,
    input logic        irq_flag,
    input logic [15:0] data_word,
    input logic [15:0] status_word
);
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !flag_clear |=> irq_flag);

    p_words_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !flag_clear |=> $stable(data_word) && $stable(status_word));

    p_ack_drops_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && flag_clear |=> !irq_flag);

    p_chan_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> data_word[14:10] == status_word[14:10]);

    p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> data_word[15] == ^data_word[7:0]);

    p_zero_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> !status_word[15] && status_word[9:4] == 6'd0
                     && !(status_word[0] && status_word[3]));

    p_diag_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && status_word[3] |->
            (32'(status_word[14:10]) >= USER_N) && (32'(status_word[14:10]) < USER_N + DIAG_N));

    p_tx_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && status_word[0] |-> 32'(status_word[14:10]) < USER_N);

    p_user_rx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !status_word[0] && !status_word[3] |-> 32'(status_word[14:10]) < USER_N);
endmodule

bind line_irq_scanner line_irq_scanner_chk #(.USER_N(USER_N), .DIAG_N(DIAG_N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_clear  (flag_clear),
    .irq_flag    (irq_flag),
    .data_word   (data_word),
    .status_word (status_word)
);

// File: tb/line_irq_scanner_bench.sv
`timescale 1ns/1ps
module line_irq_scanner_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [4:0]  rx_chan = '0;
    logic [9:0]  rx_char = '0;
    logic        rx_break = 1'b0;
    logic        tx_valid = 1'b0;
    logic [4:0]  tx_chan = '0;
    logic [20:0] rx_enable = '0;
    logic [15:0] tx_enable = '0;
    logic        flag_clear = 1'b0;
    logic        irq_flag;
    logic [15:0] data_word, status_word;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    line_irq_scanner u_line_irq_scanner (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit          m_pend [21];
    bit          m_done [16];
    bit          m_brk  [21];
    bit          m_lost [21];
    int          m_chr  [21];
    bit          m_flag = 0;
    logic [15:0] m_data = '0, m_stat = '0;

    function automatic logic [15:0] mk_data(int ch, int c);
        int ones = 0;
        for (int b = 0; b < 8; b++) ones += (c >> b) & 1;
        return {ones % 2 == 1, 5'(ch), 10'(c)};
    endfunction

    function automatic logic [15:0] mk_stat(int ch, bit dg, bit bk, bit ls, bit tx);
        return {1'b0, 5'(ch), 6'd0, dg, bk, ls, tx};
    endfunction

    always @(posedge clk) begin
        int sc, scls, c;
        if (!rst_n) begin
            for (int i = 0; i < 21; i++) begin
                m_pend[i] = 0; m_brk[i] = 0; m_lost[i] = 0; m_chr[i] = 0;
            end
            for (int i = 0; i < 16; i++) m_done[i] = 0;
            m_flag = 0; m_data = '0; m_stat = '0;
        end else begin
            sc = -1; scls = 0;
            if (!m_flag) begin
                for (int i = 0; i < 16; i++)
                    if (sc < 0 && m_pend[i] && rx_enable[i]) begin sc = i; scls = 0; end
                for (int i = 0; i < 16; i++)
                    if (sc < 0 && m_done[i] && tx_enable[i]) begin sc = i; scls = 1; end
                for (int i = 16; i < 21; i++)
                    if (sc < 0 && m_pend[i] && rx_enable[i]) begin sc = i; scls = 2; end
                if (sc >= 0) begin
                    m_data = mk_data(sc, m_chr[sc]);
                    m_stat = mk_stat(sc, scls == 2, m_brk[sc], m_lost[sc], scls == 1);
                    m_flag = 1;
                    m_brk[sc] = 0; m_lost[sc] = 0;
                    if (scls == 1) m_done[sc] = 0; else m_pend[sc] = 0;
                end
            end else if (flag_clear) begin
                m_flag = 0;
            end
            if (rx_valid && rx_chan < 21) begin
                c = int'(rx_chan);
                if (rx_break) begin
                    m_brk[c] = 1; m_chr[c] = 0;
                end else begin
                    if (m_pend[c]) m_lost[c] = 1;
                    m_chr[c] = int'(rx_char);
                end
                m_pend[c] = 1;
            end
            if (tx_valid && tx_chan < 16) m_done[tx_chan] = 1;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R11 model flag", 16'(irq_flag), 16'(m_flag));
            chk("R5 model data", data_word, m_data);
            chk("R6 model status", status_word, m_stat);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_rx(input int ch, input int c, input bit b);
        rx_valid = 1; rx_chan = 5'(ch); rx_char = 10'(c); rx_break = b;
        step();
        rx_valid = 0; rx_break = 0;
    endtask

    task automatic send_tx(input int ch);
        tx_valid = 1; tx_chan = 5'(ch);
        step();
        tx_valid = 0;
    endtask

    task automatic ack();
        flag_clear = 1;
        step();
        flag_clear = 0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 flag", 16'(irq_flag), 16'd0);
        chk("R1 data", data_word, 16'd0);
        chk("R1 status", status_word, 16'd0);
        rx_enable = '1;
        tx_enable = '1;

        // R5/R8 basic receive: flag rises one edge after capture
        send_rx(5, 10'h0A3, 0);
        chk("R8 not yet posted", 16'(irq_flag), 16'd0);
        step();
        chk("R8 posted", 16'(irq_flag), 16'd1);
        chk("R5 data line5", data_word, mk_data(5, 10'h0A3));
        chk("R6 status line5", status_word, mk_stat(5, 0, 0, 0, 0));

        // R2/R3 order, events stored while the flag is held
        rx_valid = 1; rx_chan = 5'd9; rx_char = 10'h011;
        tx_valid = 1; tx_chan = 5'd2;
        step();
        rx_valid = 0; tx_valid = 0;
        send_rx(17, 10'h3FF, 0);
        send_rx(3, 10'h2C7, 0);
        step();
        chk("R11 held data", data_word, mk_data(5, 10'h0A3));
        ack(); step();
        chk("R3 first rx line3", data_word, mk_data(3, 10'h2C7));
        ack(); step();
        chk("R3 second rx line9", status_word, mk_stat(9, 0, 0, 0, 0));
        ack(); step();
        chk("R2 tx after rx", status_word, mk_stat(2, 0, 0, 0, 1));
        ack(); step();
        chk("R2 diag last", status_word, mk_stat(17, 1, 0, 0, 0));
        chk("R2 diag data", data_word, mk_data(17, 10'h3FF));
        ack(); step();
        chk("R8 nothing left", 16'(irq_flag), 16'd0);

        // R7 transmit reports last received char of the line
        send_tx(3); step();
        chk("R7 tx data", data_word, mk_data(3, 10'h2C7));
        chk("R7 tx status", status_word, mk_stat(3, 0, 0, 0, 1));

        // R9 break, R10 lost
        send_rx(4, 10'h155, 1);
        send_rx(6, 10'h041, 0);
        send_rx(6, 10'h042, 0);
        ack(); step();
        chk("R9 break data", data_word, mk_data(4, 0));
        chk("R9 break status", status_word, mk_stat(4, 0, 1, 0, 0));
        ack(); step();
        chk("R10 lost data", data_word, mk_data(6, 10'h042));
        chk("R10 lost status", status_word, mk_stat(6, 0, 0, 1, 0));
        ack(); step();
        chk("R8 cleared after service", 16'(irq_flag), 16'd0);

        // R4 enable gating
        rx_enable[7] = 0;
        send_rx(7, 10'h0F0, 0);
        repeat (3) step();
        chk("R4 disabled no irq", 16'(irq_flag), 16'd0);
        rx_enable[7] = 1;
        step();
        chk("R4 enabled posts", status_word, mk_stat(7, 0, 0, 0, 0));
        ack(); step();

        // R12 out-of-range channels ignored
        send_rx(25, 10'h001, 0);
        send_tx(18);
        repeat (2) step();
        chk("R12 no irq", 16'(irq_flag), 16'd0);

        // R11 clear while low has no effect; rescan after ack
        ack();
        chk("R11 clear while low", 16'(irq_flag), 16'd0);
        send_rx(1, 10'h2AA, 0);
        step();
        chk("R11 posted", 16'(irq_flag), 16'd1);
        repeat (4) step();
        chk("R11 hold", data_word, mk_data(1, 10'h2AA));
        ack();
        chk("R11 ack drops", 16'(irq_flag), 16'd0);

        // random traffic compared cycle by cycle against the model (R2-R12)
        for (int k = 0; k < 3000; k++) begin
            rx_valid   = ($urandom % 10) < 3;
            rx_chan    = 5'($urandom % 25);
            rx_char    = 10'($urandom);
            rx_break   = ($urandom % 10) == 0;
            tx_valid   = ($urandom % 5) == 0;
            tx_chan    = 5'($urandom % 18);
            flag_clear = ($urandom % 3) == 0;
            if (k % 200 == 0) begin
                rx_enable = 21'($urandom) | 21'h1F0F0;
                tx_enable = 16'($urandom) | 16'h0F0F;
            end
            step();
        end
        rx_valid = 0; tx_valid = 0; flag_clear = 0;
        repeat (2) step();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule